// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Command Decoder

This block takes complete 16-bit command words, already assembled by a serial receiver elsewhere, and applies them to two converter channels. Each channel holds a staging (input) register and a live (output) register of 12 bits. Words can stage data, publish staged data, or do both in one step, either on one channel or on both together. The block also keeps a shutdown flag per channel, a general-purpose user output bit and a bit that selects which serial clock edge launches the data output.

A word is accepted when its valid strobe is high on a rising clock edge. It takes effect on the next rising edge. An active-low lockout input stops every shutdown request while it is low. It is synchronized inside the block, and when it falls it wakes both channels. An active-low asynchronous clear returns the whole block to its reset state.

Top module: `dac_cmd_decoder`

## Requirements
- R1: Reset (rst_ni low) or clear (clr_ni low) forces, asynchronously, both input registers and both output registers to zero, both shutdown flags to 0, user_o to 0 and mode_rise_o to 0 (falling-edge launch).
- R2: Word fields are: word_i[15:13] = opcode (bit 15 is the address bit), word_i[12:1] = data D11..D0, word_i[0] = trailing bit. The trailing bit is ignored. A word sampled with word_valid_i high at edge k changes the outputs at edge k+1.
- R3: Opcode 001 writes the data into input register A and opcode 101 writes it into input register B. Neither changes an output register.
- R4: Opcode 010 writes the data into input and output register A and copies input register B into output register B. Opcode 110 writes the data into input and output register B and copies input register A into output register A.
- R5: Opcode 011 writes the data into all four registers.
- R6: Opcode 100 copies each input register into its output register. With opcode 000, D11..D9 = 001 copies A only and D11..D9 = 101 copies B only.
- R7: When lockout is high, opcode 111 sets both shutdown flags, and opcode 000 with D11..D9 = 110 or 111 sets the flag of channel A or channel B. Shutdown changes no register contents, and input registers can still be loaded while a channel is shut down.
- R8: While the synchronized lockout is low, every shutdown request has no effect.
- R9: A high-to-low transition of lockout clears both shutdown flags and keeps every register. The flags clear three clock edges after the input falls.
- R10: Any write to a channel's output register clears that channel's shutdown flag.
- R11: Opcode 000 with D11..D9 = 010 drives user_o low, and with D11..D9 = 011 drives it high.
- R12: Opcode 000 with D11..D9 = 100 copies D8 into mode_rise_o (1 = rising-edge launch). Opcode 000 with D11..D9 = 000 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clr_ni | input | 1 | Active-low asynchronous clear of all state |
| lock_ni | input | 1 | Shutdown lockout; low blocks shutdown, falling edge wakes |
| word_i | input | 16 | Command word |
| word_valid_i | input | 1 | Command word strobe |
| out_a_o | output | 12 | Output register of channel A |
| out_b_o | output | 12 | Output register of channel B |
| sd_a_o | output | 1 | Shutdown flag of channel A |
| sd_b_o | output | 1 | Shutdown flag of channel B |
| user_o | output | 1 | User logic output |
| mode_rise_o | output | 1 | Data-output launch edge select, 1 = rising |

## Verification
The bench builds the block with DATA_W = 12 and SYNC_STAGES = 2. With 12 bits it can use full-scale and alternating data patterns that separate the staged value from the live value on every channel. With two synchronizer stages the wake after a lockout fall lands exactly three edges after the input moves, so a scoreboard entry can be timed to that edge. Back-to-back words exercise the one-cycle execute pipeline. Lockout is held low through several shutdown requests to show that they are blocked.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic [2:0] {
    OP_SUB     = 3'b000,
    OP_LD_A    = 3'b001,
    OP_LDA_UPD = 3'b010,
    OP_LD_ALL  = 3'b011,
    OP_RECALL  = 3'b100,
    OP_LD_B    = 3'b101,
    OP_LDB_UPD = 3'b110,
    OP_SD_ALL  = 3'b111
  } op_e;

  typedef enum logic [2:0] {
    SUB_NOP    = 3'b000,
    SUB_RCL_A  = 3'b001,
    SUB_USR_LO = 3'b010,
    SUB_USR_HI = 3'b011,
    SUB_MODE   = 3'b100,
    SUB_RCL_B  = 3'b101,
    SUB_SD_A   = 3'b110,
    SUB_SD_B   = 3'b111
  } sub_e;

  typedef struct packed {
    logic load_in;
    logic load_out;
    logic out_new;   // output takes word data instead of staged value
    logic sd_set;
  } ch_ctl_t;
endpackage

// File: rtl/dcd_lock_sync.sv
module dcd_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_ni,
  output logic lock_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              lock_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      lock_d <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], lock_ni};
      lock_d <= sync_q[STAGES-1];
    end
  end

  assign lock_o = sync_q[STAGES-1];
  assign fall_o = lock_d & ~lock_o;
endmodule

// File: rtl/dcd_decode.sv
module dcd_decode
  import dcd_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                 valid_i,
  input  logic [DATA_W+3:1]    word_i,
  input  logic                 lock_i,
  output ch_ctl_t [NUM_CH-1:0] ctl_o,
  output logic [DATA_W-1:0]    data_o,
  output logic                 user_set_o,
  output logic                 user_clr_o,
  output logic                 mode_wr_o,
  output logic                 mode_val_o
);
  localparam int WORD_W = DATA_W + 4;

  op_e  op;
  sub_e sub;

  assign op         = op_e'(word_i[WORD_W-1:WORD_W-3]);
  assign sub        = sub_e'(word_i[DATA_W:DATA_W-2]);
  assign data_o     = word_i[DATA_W:1];
  assign mode_val_o = word_i[DATA_W-3];

  always_comb begin
    ctl_o      = '0;
    user_set_o = 1'b0;
    user_clr_o = 1'b0;
    mode_wr_o  = 1'b0;
    if (valid_i) begin
      case (op)
        OP_LD_A: ctl_o[0].load_in = 1'b1;
        OP_LD_B: ctl_o[1].load_in = 1'b1;
        OP_LDA_UPD: begin
          ctl_o[0].load_in  = 1'b1;
          ctl_o[0].out_new  = 1'b1;
          ctl_o[0].load_out = 1'b1;
          ctl_o[1].load_out = 1'b1;
        end
        OP_LDB_UPD: begin
          ctl_o[1].load_in  = 1'b1;
          ctl_o[1].out_new  = 1'b1;
          ctl_o[1].load_out = 1'b1;
          ctl_o[0].load_out = 1'b1;
        end
        OP_LD_ALL: begin
          for (int i = 0; i < NUM_CH; i++) begin
            ctl_o[i].load_in  = 1'b1;
            ctl_o[i].out_new  = 1'b1;
            ctl_o[i].load_out = 1'b1;
          end
        end
        OP_RECALL: begin
          for (int i = 0; i < NUM_CH; i++) ctl_o[i].load_out = 1'b1;
        end
        OP_SD_ALL: begin
          for (int i = 0; i < NUM_CH; i++) ctl_o[i].sd_set = lock_i;
        end
        default: begin
          case (sub)
            SUB_RCL_A:  ctl_o[0].load_out = 1'b1;
            SUB_RCL_B:  ctl_o[1].load_out = 1'b1;
            SUB_SD_A:   ctl_o[0].sd_set   = lock_i;
            SUB_SD_B:   ctl_o[1].sd_set   = lock_i;
            SUB_USR_LO: user_clr_o        = 1'b1;
            SUB_USR_HI: user_set_o        = 1'b1;
            SUB_MODE:   mode_wr_o         = 1'b1;
            default: ;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/dcd_channel.sv
module dcd_channel
  import dcd_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ch_ctl_t           ctl_i,
  input  logic              wake_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] out_o,
  output logic              sd_o
);
  logic [DATA_W-1:0] in_q, out_q;
  logic              sd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      out_q <= '0;
      sd_q  <= 1'b0;
    end else begin
      if (ctl_i.load_in) in_q <= data_i;
      if (ctl_i.load_out) out_q <= ctl_i.out_new ? data_i : in_q;
      if (ctl_i.load_out || wake_i) sd_q <= 1'b0;
      else if (ctl_i.sd_set)        sd_q <= 1'b1;
    end
  end

  assign out_o = out_q;
  assign sd_o  = sd_q;

  a_r10_update_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.load_out |=> !sd_q);

  a_r7_out_frozen_in_sd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_q && $past(sd_q)) |-> $stable(out_q));

  a_r7_sd_keeps_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.sd_set && !ctl_i.load_in) |=> $stable(in_q));
endmodule

// File: rtl/dac_cmd_decoder.sv
module dac_cmd_decoder
  import dcd_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_ni,
  input  logic              lock_ni,
  input  logic [DATA_W+3:0] word_i,
  input  logic              word_valid_i,
  output logic [DATA_W-1:0] out_a_o,
  output logic [DATA_W-1:0] out_b_o,
  output logic              sd_a_o,
  output logic              sd_b_o,
  output logic              user_o,
  output logic              mode_rise_o
);
  localparam int WORD_W = DATA_W + 4;

  logic rst_n;
  assign rst_n = rst_ni & clr_ni;

  // trailing bit of the word carries no meaning
  logic s0_unused;
  assign s0_unused = word_i[0];

  logic [WORD_W-1:1] cmd_q;
  logic              vld_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= word_valid_i;
      if (word_valid_i) cmd_q <= word_i[WORD_W-1:1];
    end
  end

  logic lock_s, lock_fall;

  dcd_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .lock_ni (lock_ni),
    .lock_o  (lock_s),
    .fall_o  (lock_fall)
  );

  ch_ctl_t [NUM_CH-1:0] ctl;
  logic [DATA_W-1:0]    data;
  logic                 user_set, user_clr, mode_wr, mode_val;

  dcd_decode #(.DATA_W(DATA_W)) u_dec (
    .valid_i    (vld_q),
    .word_i     (cmd_q),
    .lock_i     (lock_s),
    .ctl_o      (ctl),
    .data_o     (data),
    .user_set_o (user_set),
    .user_clr_o (user_clr),
    .mode_wr_o  (mode_wr),
    .mode_val_o (mode_val)
  );

  logic [DATA_W-1:0] out_arr [NUM_CH];
  logic [NUM_CH-1:0] sd_arr;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dcd_channel #(.DATA_W(DATA_W)) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .ctl_i  (ctl[c]),
      .wake_i (lock_fall),
      .data_i (data),
      .out_o  (out_arr[c]),
      .sd_o   (sd_arr[c])
    );

    a_r8_sd_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_n)
      $rose(sd_arr[c]) |-> $past(lock_s));
  end

  logic user_q, mode_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      user_q <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      if (user_set)      user_q <= 1'b1;
      else if (user_clr) user_q <= 1'b0;
      if (mode_wr) mode_q <= mode_val;
    end
  end

  assign out_a_o     = out_arr[0];
  assign out_b_o     = out_arr[1];
  assign sd_a_o      = sd_arr[0];
  assign sd_b_o      = sd_arr[1];
  assign user_o      = user_q;
  assign mode_rise_o = mode_q;

  a_r9_fall_wakes: assert property (@(posedge clk_i) disable iff (!rst_n)
    lock_fall |=> (sd_arr == '0));

  a_r11_user_needs_cmd: assert property (@(posedge clk_i) disable iff (!rst_n)
    $changed(user_q) |-> $past(vld_q));

  a_r12_mode_needs_cmd: assert property (@(posedge clk_i) disable iff (!rst_n)
    $changed(mode_q) |-> $past(vld_q));
endmodule

// File: tb/tb_dac_cmd_decoder.sv
`timescale 1ns/1ps
module tb_dac_cmd_decoder;
  localparam int DW = 12;
  localparam int EW = 2*DW + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0, clr_n = 1'b1, lock_n = 1'b1;
  logic [DW+3:0] word = '0;
  logic vld = 1'b0;
  logic [DW-1:0] out_a, out_b;
  logic sd_a, sd_b, user, mode;

  always #2.5 clk = ~clk;

  dac_cmd_decoder #(.DATA_W(DW), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .lock_ni(lock_n),
    .word_i(word), .word_valid_i(vld),
    .out_a_o(out_a), .out_b_o(out_b), .sd_a_o(sd_a), .sd_b_o(sd_b),
    .user_o(user), .mode_rise_o(mode)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  // reference model
  logic [DW-1:0] m_in_a = '0, m_in_b = '0, m_out_a = '0, m_out_b = '0;
  logic m_sd_a = 0, m_sd_b = 0, m_user = 0, m_mode = 0, m_lock = 1;

  int            q_due[$];
  logic [EW-1:0] q_exp[$];
  string         q_tag[$];

  function automatic logic [EW-1:0] model_vec();
    return {m_out_a, m_out_b, m_sd_a, m_sd_b, m_user, m_mode};
  endfunction

  function automatic logic [EW-1:0] dut_vec();
    return {out_a, out_b, sd_a, sd_b, user, mode};
  endfunction

  task automatic compare(input logic [EW-1:0] exp, input string tag);
    vectors++;
    if (dut_vec() !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, dut_vec(), exp);
    end
  endtask

  // monitor: pops scoreboard items on their due cycle
  always @(negedge clk) begin
    while (q_due.size() > 0 && q_due[0] <= cyc) begin
      int due;
      logic [EW-1:0] e;
      string t;
      due = q_due.pop_front();
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      compare(e, t);
    end
  end

  task automatic push(input int due, input string tag);
    q_due.push_back(due);
    q_exp.push_back(model_vec());
    q_tag.push_back(tag);
  endtask

  // driver: called at a negedge; outputs move two edges later
  task automatic send(input logic [2:0] op, input logic [DW-1:0] d,
                      input logic s0, input string tag);
    logic [2:0] sub;
    sub = d[DW-1 -: 3];
    case (op)
      3'b001: m_in_a = d;
      3'b101: m_in_b = d;
      3'b010: begin m_in_a = d; m_out_a = d; m_out_b = m_in_b; m_sd_a = 0; m_sd_b = 0; end
      3'b110: begin m_in_b = d; m_out_b = d; m_out_a = m_in_a; m_sd_a = 0; m_sd_b = 0; end
      3'b011: begin m_in_a = d; m_in_b = d; m_out_a = d; m_out_b = d; m_sd_a = 0; m_sd_b = 0; end
      3'b100: begin m_out_a = m_in_a; m_out_b = m_in_b; m_sd_a = 0; m_sd_b = 0; end
      3'b111: if (m_lock) begin m_sd_a = 1; m_sd_b = 1; end
      default: case (sub)
        3'b001: begin m_out_a = m_in_a; m_sd_a = 0; end
        3'b101: begin m_out_b = m_in_b; m_sd_b = 0; end
        3'b110: if (m_lock) m_sd_a = 1;
        3'b111: if (m_lock) m_sd_b = 1;
        3'b010: m_user = 0;
        3'b011: m_user = 1;
        3'b100: m_mode = d[DW-4];
        default: ;
      endcase
    endcase
    word = {op, d, s0};
    vld = 1'b1;
    push(cyc + 2, tag);
    @(negedge clk);
    vld = 1'b0;
    word = '1;
  endtask

  task automatic set_lock(input logic v, input string tag);
    lock_n = v;
    if (m_lock && !v) begin
      m_sd_a = 0; m_sd_b = 0;
      push(cyc + 3, tag);
    end
    m_lock = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog all-requirements actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(model_vec(), "R1 reset state");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3: stage only
    send(3'b001, 12'hABC, 0, "R3 stage A leaves outputs");
    send(3'b101, 12'h123, 0, "R3 stage B leaves outputs");
    // R6: recall both
    send(3'b100, 12'h000, 0, "R6 recall both");
    // R4: stage and publish
    send(3'b010, 12'h5A5, 0, "R4 new A, staged B");
    send(3'b110, 12'hFFF, 0, "R4 new B, staged A");
    // R5: load all
    send(3'b011, 12'h7E1, 0, "R5 load all four");
    // R6: single-channel recall
    send(3'b001, 12'h111, 0, "R3 stage A");
    send(3'b000, 12'h200, 0, "R6 recall A only");
    send(3'b101, 12'h222, 0, "R3 stage B");
    send(3'b000, 12'hA00, 0, "R6 recall B only");
    // R2: trailing bit ignored
    send(3'b001, 12'h333, 1, "R2 trailing bit set stage A");
    send(3'b000, 12'h200, 1, "R2 trailing bit set recall A");
    // R7: shutdown both, staging still works
    send(3'b111, 12'hFFF, 0, "R7 shutdown both");
    send(3'b001, 12'h444, 0, "R7 stage A in shutdown");
    // R10: recall wakes only the updated channel
    send(3'b000, 12'h200, 0, "R10 recall A wakes A");
    send(3'b100, 12'h000, 0, "R10 recall both wakes B");
    // R7: per-channel shutdown
    send(3'b000, 12'hC00, 0, "R7 shutdown A");
    send(3'b000, 12'hE00, 0, "R7 shutdown B");
    drain();
    // R9: lockout fall wakes both
    set_lock(1'b0, "R9 lockout fall wakes both");
    // R8: lockout low blocks shutdown
    send(3'b111, 12'h000, 0, "R8 blocked shutdown both");
    send(3'b000, 12'hC00, 0, "R8 blocked shutdown A");
    send(3'b000, 12'hE00, 0, "R8 blocked shutdown B");
    drain();
    set_lock(1'b1, "R9 lockout rise no effect");
    // R11: user output
    send(3'b000, 12'h600, 0, "R11 user high");
    send(3'b000, 12'h400, 0, "R11 user low");
    send(3'b000, 12'h600, 0, "R11 user high again");
    // R12: mode and nop
    send(3'b000, 12'h900, 0, "R12 mode rising");
    send(3'b000, 12'h0FF, 1, "R12 nop");
    send(3'b000, 12'h800, 0, "R12 mode falling");
    send(3'b000, 12'h900, 0, "R12 mode rising again");
    send(3'b111, 12'h000, 0, "R7 shutdown before clear");
    drain();
    // R1: asynchronous clear
    clr_n = 1'b0;
    #1;
    m_in_a = '0; m_in_b = '0; m_out_a = '0; m_out_b = '0;
    m_sd_a = 0; m_sd_b = 0; m_user = 0; m_mode = 0;
    compare(model_vec(), "R1 async clear");
    @(negedge clk);
    clr_n = 1'b1;
    repeat (4) @(negedge clk);
    send(3'b000, 12'h200, 0, "R1 recall after clear gives zero");
    drain();
    if (q_due.size() != 0) begin
      miscompares++;
      $display("FAIL R2 scoreboard actual=%0d expected=0 pending", q_due.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule